// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

The block puts two eight-input interrupt controllers, a master and a slave, behind one byte-wide I/O port decoder, which gives sixteen interrupt lines. Line events arrive as raise or lower strobes that carry a line number. The block routes each event to the controller that owns the line, combines the unmasked requests of both controllers into a single pending output, and presents the vector that an acknowledge would deliver. When an acknowledge arrives, the selected line moves from the request register to the in-service register.

Each controller has its own initialization sequencer with five named states. `SEQ_IDLE` waits for the first init word. A command-port write with bit 4 set goes to `SEQ_BASE` from any state. A data write in `SEQ_BASE` stores the vector base and moves to `SEQ_CASC`, `SEQ_MODE` or `SEQ_RUN`, depending on the controller's own first word. A data write in `SEQ_CASC` moves to `SEQ_MODE` or `SEQ_RUN`. A data write in `SEQ_MODE` moves to `SEQ_RUN`. Data writes in `SEQ_IDLE` and `SEQ_RUN` update the mask register. Only in `SEQ_RUN` does a command write act as an end-of-interrupt or read-select word.

Each controller also has a trigger-mode register at a port of its own. A fixed write mask keeps certain system lines edge-triggered. A line marked level-triggered keeps its request bit when it is acknowledged.

Top module: `pic_cascade_pair`

## Requirements
- R1: Port 0x20 is the master command port and 0x21 the master data port. Port 0xA0 is the slave command port and 0xA1 the slave data port. Ports 0x4D0 and 0x4D1 are the master and slave trigger registers. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: After reset, both controllers are in `SEQ_IDLE`. The request, in-service, mask, base and trigger registers are all zero, and the read select points at the request register.
- R3: A command write with bit 4 set stores the first init word and enters `SEQ_BASE` from any state. A data write in `SEQ_BASE` stores the vector base. It then goes to `SEQ_CASC` if bit 1 of that controller's own first word is 0. Otherwise it goes to `SEQ_MODE` if bit 0 is 1, and to `SEQ_RUN` if not. A data write in `SEQ_CASC` goes to `SEQ_MODE` if bit 0 is 1 and to `SEQ_RUN` if not. A data write in `SEQ_MODE` goes to `SEQ_RUN`. None of these init data writes alter the mask.
- R4: A data-port write in `SEQ_IDLE` or `SEQ_RUN` loads the mask register. A data-port read returns the mask.
- R5: In `SEQ_RUN`, a command write with bits 4:3 equal to 01 sets the read select from bits 1:0. With 10, a command-port read returns the request register. With 11, it returns the in-service register. With any other value, it returns 0x00.
- R6: A write to a trigger register stores the data ANDed with 0xF8 for the master and 0xDE for the slave. The register reads back at its port.
- R7: Raising line n (0..7) sets master request bit n. Raising line n (8..15) sets slave request bit n-8. Any valid raise also sets master request bit 2. A line number of 16 or more is ignored.
- R8: Lowering a valid line clears only that line's request bit.
- R9: `int_pending` is high exactly when either controller has a request bit that is not masked.
- R10: `int_vector` is the master base plus the lowest unmasked master request bit. If there is no such bit, it is the slave base plus the lowest unmasked slave request bit. With nothing pending, it is 0x00.
- R11: An acknowledge while pending sets the in-service bit of the selected line. It clears the line's request bit if the line is edge-triggered (trigger bit 0) and keeps it if the line is level-triggered.
- R12: In `SEQ_RUN`, a command write with bits 4:3 equal to 00 is an end-of-interrupt word. Bits 7:5 = 011 clear the in-service bit numbered by bits 2:0. Bits 7:5 = 001 clear the lowest set in-service bit. Any other value changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe; io_rdata is valid in the same cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0x00 when io_rd is low |
| irq_raise | input | 1 | Raise the line given by irq_num |
| irq_lower | input | 1 | Lower the line given by irq_num |
| irq_num | input | 5 | Line number for a raise or lower |
| int_ack | input | 1 | Acknowledge of the presented vector |
| int_pending | output | 1 | An unmasked request exists |
| int_vector | output | 8 | Vector that an acknowledge would deliver |

## Verification
Several properties are checked on every cycle: the trigger registers never hold a bit outside their write masks, the pending output agrees with the unmasked request state, every valid raise leaves master bit 2 set, out-of-range raises leave both request registers untouched, a first init word always restarts the sequencer, and an acknowledge while pending leaves an in-service bit set. Other behaviour only the bench scenarios can show. This includes the exact path through the init words, in particular the slave following its own first word; the master-first priority and the resulting vectors; the level/edge difference on acknowledge; the two end-of-interrupt forms; and the read-select choices on the command port.

// File: rtl/pic_pair_pkg.sv
package pic_pair_pkg;
    localparam int BYTE_W     = 8;
    localparam int CTRL_LINES = 8;
    localparam int LVL_W      = $clog2(CTRL_LINES);
    localparam int LINE_NUM_W = 5;
    localparam int NUM_CTRL   = 2;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_BASE,
        SEQ_CASC,
        SEQ_MODE,
        SEQ_RUN
    } seq_state_t;

    localparam logic [1:0] RSEL_REQ = 2'b10;
    localparam logic [1:0] RSEL_SVC = 2'b11;
endpackage

// File: rtl/pic_port_dec.sv
module pic_port_dec
    import pic_pair_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] M_CMD  = 16'h0020,
    parameter logic [ADDR_W-1:0] M_DATA = 16'h0021,
    parameter logic [ADDR_W-1:0] S_CMD  = 16'h00A0,
    parameter logic [ADDR_W-1:0] S_DATA = 16'h00A1,
    parameter logic [ADDR_W-1:0] M_TRIG = 16'h04D0,
    parameter logic [ADDR_W-1:0] S_TRIG = 16'h04D1
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              wr,
    input  logic                              rd,
    input  logic [NUM_CTRL-1:0][BYTE_W-1:0]   cmd_rval,
    input  logic [NUM_CTRL-1:0][BYTE_W-1:0]   data_rval,
    input  logic [NUM_CTRL-1:0][BYTE_W-1:0]   trig_rval,
    output logic [NUM_CTRL-1:0]               cmd_wr,
    output logic [NUM_CTRL-1:0]               data_wr,
    output logic [NUM_CTRL-1:0]               trig_wr,
    output logic [BYTE_W-1:0]                 rdata
);
    logic [NUM_CTRL-1:0] hit_cmd, hit_data, hit_trig;

    assign hit_cmd  = {addr == S_CMD,  addr == M_CMD};
    assign hit_data = {addr == S_DATA, addr == M_DATA};
    assign hit_trig = {addr == S_TRIG, addr == M_TRIG};

    assign cmd_wr  = wr ? hit_cmd  : '0;
    assign data_wr = wr ? hit_data : '0;
    assign trig_wr = wr ? hit_trig : '0;

    always_comb begin
        rdata = '0;
        if (rd) begin
            for (int c = 0; c < NUM_CTRL; c++) begin
                if (hit_cmd[c])  rdata = cmd_rval[c];
                if (hit_data[c]) rdata = data_rval[c];
                if (hit_trig[c]) rdata = trig_rval[c];
            end
        end
    end
endmodule

// File: rtl/pic_lowest_pick.sv
module pic_lowest_pick
    import pic_pair_pkg::*;
(
    input  logic [CTRL_LINES-1:0] req,
    output logic                  found,
    output logic [LVL_W-1:0]      idx,
    output logic [CTRL_LINES-1:0] hot
);
    assign hot   = req & (~req + CTRL_LINES'(1));
    assign found = |req;

    always_comb begin
        idx = '0;
        for (int i = CTRL_LINES - 1; i >= 0; i--) begin
            if (req[i]) idx = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic_ctrl_core.sv
module pic_ctrl_core
    import pic_pair_pkg::*;
#(
    parameter logic [CTRL_LINES-1:0] TRIG_MASK = 8'hF8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic                  data_wr,
    input  logic                  trig_wr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic [CTRL_LINES-1:0] raise_set,
    input  logic [CTRL_LINES-1:0] lower_clr,
    input  logic [CTRL_LINES-1:0] ack_hot,
    output logic [CTRL_LINES-1:0] irr,
    output logic [CTRL_LINES-1:0] isr,
    output logic [CTRL_LINES-1:0] imr,
    output logic [CTRL_LINES-1:0] trig,
    output logic [BYTE_W-1:0]     base,
    output logic [BYTE_W-1:0]     cmd_rdata,
    output seq_state_t            state
);
    seq_state_t              state_q, state_d;
    logic [BYTE_W-1:0]       first_q;
    logic [1:0]              rsel_q;
    logic                    is_first, is_eoi, is_sel;
    logic [CTRL_LINES-1:0]   isr_set, eoi_clr, isr_low;

    assign is_first = cmd_wr && wdata[4];
    assign is_eoi   = cmd_wr && (state_q == SEQ_RUN) && (wdata[4:3] == 2'b00);
    assign is_sel   = cmd_wr && (state_q == SEQ_RUN) && (wdata[4:3] == 2'b01);

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // sequencer next state
    always_comb begin
        state_d = state_q;
        if (is_first) begin
            state_d = SEQ_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                SEQ_IDLE: state_d = SEQ_IDLE;
                SEQ_BASE: state_d = !first_q[1] ? SEQ_CASC :
                                    (first_q[0] ? SEQ_MODE : SEQ_RUN);
                SEQ_CASC: state_d = first_q[0] ? SEQ_MODE : SEQ_RUN;
                SEQ_MODE: state_d = SEQ_RUN;
                SEQ_RUN:  state_d = SEQ_RUN;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    // end-of-interrupt decode
    assign isr_set = isr | ack_hot;
    assign isr_low = isr_set & (~isr_set + CTRL_LINES'(1));
    always_comb begin
        eoi_clr = '0;
        if (is_eoi) begin
            unique case (wdata[7:5])
                3'b011:  eoi_clr = CTRL_LINES'(1) << wdata[LVL_W-1:0];
                3'b001:  eoi_clr = isr_low;
                default: eoi_clr = '0;
            endcase
        end
    end

    // register file outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            base    <= '0;
            imr     <= '0;
            irr     <= '0;
            isr     <= '0;
            trig    <= '0;
            rsel_q  <= RSEL_REQ;
        end else begin
            irr <= (irr | raise_set) & ~lower_clr & ~(ack_hot & ~trig);
            isr <= isr_set & ~eoi_clr;
            if (is_first) first_q <= wdata;
            if (data_wr && state_q == SEQ_BASE) base <= wdata;
            if (data_wr && (state_q == SEQ_IDLE || state_q == SEQ_RUN)) imr <= wdata;
            if (is_sel) rsel_q <= wdata[1:0];
            if (trig_wr) trig <= wdata & TRIG_MASK;
        end
    end

    always_comb begin
        unique case (rsel_q)
            RSEL_REQ: cmd_rdata = irr;
            RSEL_SVC: cmd_rdata = isr;
            default:  cmd_rdata = '0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
    import pic_pair_pkg::*;
#(
    parameter int                    ADDR_W       = 16,
    parameter logic [ADDR_W-1:0]     M_CMD_PORT   = 16'h0020,
    parameter logic [ADDR_W-1:0]     M_DATA_PORT  = 16'h0021,
    parameter logic [ADDR_W-1:0]     S_CMD_PORT   = 16'h00A0,
    parameter logic [ADDR_W-1:0]     S_DATA_PORT  = 16'h00A1,
    parameter logic [ADDR_W-1:0]     M_TRIG_PORT  = 16'h04D0,
    parameter logic [ADDR_W-1:0]     S_TRIG_PORT  = 16'h04D1,
    parameter logic [CTRL_LINES-1:0] M_TRIG_MASK  = 8'hF8,
    parameter logic [CTRL_LINES-1:0] S_TRIG_MASK  = 8'hDE,
    parameter int                    CASCADE_LINE = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [BYTE_W-1:0]     io_wdata,
    output logic [BYTE_W-1:0]     io_rdata,
    input  logic                  irq_raise,
    input  logic                  irq_lower,
    input  logic [LINE_NUM_W-1:0] irq_num,
    input  logic                  int_ack,
    output logic                  int_pending,
    output logic [BYTE_W-1:0]     int_vector
);
    localparam int LINE_TOTAL = NUM_CTRL * CTRL_LINES;

    logic [NUM_CTRL-1:0]                 cmd_wr, data_wr, trig_wr;
    logic [NUM_CTRL-1:0][BYTE_W-1:0]     cmd_rval, data_rval, trig_rval;
    logic [CTRL_LINES-1:0]               irr_a [NUM_CTRL];
    logic [CTRL_LINES-1:0]               isr_a [NUM_CTRL];
    logic [CTRL_LINES-1:0]               imr_a [NUM_CTRL];
    logic [CTRL_LINES-1:0]               trig_a[NUM_CTRL];
    logic [BYTE_W-1:0]                   base_a[NUM_CTRL];
    seq_state_t                          st_a  [NUM_CTRL];
    logic [CTRL_LINES-1:0]               raise_a[NUM_CTRL];
    logic [CTRL_LINES-1:0]               lower_a[NUM_CTRL];
    logic [CTRL_LINES-1:0]               ack_a  [NUM_CTRL];
    logic [CTRL_LINES-1:0]               hot_a  [NUM_CTRL];
    logic [LVL_W-1:0]                    idx_a  [NUM_CTRL];
    logic [NUM_CTRL-1:0]                 found;
    logic                                num_ok;
    logic [CTRL_LINES-1:0]               line_hot;

    pic_port_dec #(
        .ADDR_W(ADDR_W),
        .M_CMD(M_CMD_PORT),   .M_DATA(M_DATA_PORT),
        .S_CMD(S_CMD_PORT),   .S_DATA(S_DATA_PORT),
        .M_TRIG(M_TRIG_PORT), .S_TRIG(S_TRIG_PORT)
    ) u_dec (
        .addr(io_addr), .wr(io_wr), .rd(io_rd),
        .cmd_rval(cmd_rval), .data_rval(data_rval), .trig_rval(trig_rval),
        .cmd_wr(cmd_wr), .data_wr(data_wr), .trig_wr(trig_wr),
        .rdata(io_rdata)
    );

    assign num_ok   = 32'(irq_num) < LINE_TOTAL;
    assign line_hot = CTRL_LINES'(1) << irq_num[LVL_W-1:0];

    generate
        for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
            logic owns;
            assign owns = num_ok && (32'(irq_num) / CTRL_LINES == g);

            if (g == 0) begin : g_master
                assign raise_a[g] = (irq_raise && owns ? line_hot : '0) |
                                    (irq_raise && num_ok ? CTRL_LINES'(1) << CASCADE_LINE : '0);
                assign ack_a[g]   = int_ack && found[g] ? hot_a[g] : '0;
            end else begin : g_slave
                assign raise_a[g] = irq_raise && owns ? line_hot : '0;
                assign ack_a[g]   = int_ack && found[g] && !(|found[g-1:0]) ? hot_a[g] : '0;
            end
            assign lower_a[g] = irq_lower && owns ? line_hot : '0;

            pic_ctrl_core #(
                .TRIG_MASK(g == 0 ? M_TRIG_MASK : S_TRIG_MASK)
            ) u_core (
                .clk(clk), .rst_n(rst_n),
                .cmd_wr(cmd_wr[g]), .data_wr(data_wr[g]), .trig_wr(trig_wr[g]),
                .wdata(io_wdata),
                .raise_set(raise_a[g]), .lower_clr(lower_a[g]), .ack_hot(ack_a[g]),
                .irr(irr_a[g]), .isr(isr_a[g]), .imr(imr_a[g]), .trig(trig_a[g]),
                .base(base_a[g]), .cmd_rdata(cmd_rval[g]), .state(st_a[g])
            );

            pic_lowest_pick u_pick (
                .req(irr_a[g] & ~imr_a[g]),
                .found(found[g]), .idx(idx_a[g]), .hot(hot_a[g])
            );

            assign data_rval[g] = imr_a[g];
            assign trig_rval[g] = trig_a[g];
        end
    endgenerate

    assign int_pending = |found;

    always_comb begin
        int_vector = '0;
        for (int c = NUM_CTRL - 1; c >= 0; c--) begin
            if (found[c]) int_vector = base_a[c] + BYTE_W'(idx_a[c]);
        end
    end
endmodule

// File: rtl/pic_cascade_pair_chk.sv
module pic_cascade_pair_chk
    import pic_pair_pkg::*;
#(
    parameter int                    ADDR_W      = 16,
    parameter logic [ADDR_W-1:0]     M_CMD_PORT  = 16'h0020,
    parameter logic [CTRL_LINES-1:0] M_TRIG_MASK = 8'hF8,
    parameter logic [CTRL_LINES-1:0] S_TRIG_MASK = 8'hDE
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     io_addr,
    input logic                  io_wr,
    input logic [BYTE_W-1:0]     io_wdata,
    input logic                  irq_raise,
    input logic                  irq_lower,
    input logic [LINE_NUM_W-1:0] irq_num,
    input logic                  int_ack,
    input logic                  int_pending,
    input logic [CTRL_LINES-1:0] m_irr,
    input logic [CTRL_LINES-1:0] m_isr,
    input logic [CTRL_LINES-1:0] m_imr,
    input logic [CTRL_LINES-1:0] m_trig,
    input logic [CTRL_LINES-1:0] s_irr,
    input logic [CTRL_LINES-1:0] s_isr,
    input logic [CTRL_LINES-1:0] s_imr,
    input logic [CTRL_LINES-1:0] s_trig,
    input seq_state_t            m_state
);
    // R6
    trig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_trig & ~M_TRIG_MASK) == '0) && ((s_trig & ~S_TRIG_MASK) == '0));

    // R9
    pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_pending == (((m_irr & ~m_imr) != '0) || ((s_irr & ~s_imr) != '0)));

    // R7
    cascade_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raise && !irq_num[LINE_NUM_W-1] && !irq_lower && !int_ack) |=> m_irr[2]);

    // R7
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raise && irq_num[LINE_NUM_W-1] && !irq_lower && !int_ack && !io_wr)
            |=> ($stable(m_irr) && $stable(s_irr)));

    // R3
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == M_CMD_PORT && io_wdata[4]) |=> (m_state == SEQ_BASE));

    // R11
    ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_pending && !io_wr) |=> ({m_isr, s_isr} != '0));
endmodule

bind pic_cascade_pair pic_cascade_pair_chk #(
    .ADDR_W(ADDR_W), .M_CMD_PORT(M_CMD_PORT),
    .M_TRIG_MASK(M_TRIG_MASK), .S_TRIG_MASK(S_TRIG_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .irq_raise(irq_raise), .irq_lower(irq_lower), .irq_num(irq_num),
    .int_ack(int_ack), .int_pending(int_pending),
    .m_irr(irr_a[0]), .m_isr(isr_a[0]), .m_imr(imr_a[0]), .m_trig(trig_a[0]),
    .s_irr(irr_a[1]), .s_isr(isr_a[1]), .s_imr(imr_a[1]), .s_trig(trig_a[1]),
    .m_state(st_a[0])
);

// File: tb/pic_cascade_pair_bench.sv
`timescale 1ns/1ps
module pic_cascade_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        irq_raise = 1'b0, irq_lower = 1'b0;
    logic [4:0]  irq_num = '0;
    logic        int_ack = 1'b0;
    logic        int_pending;
    logic [7:0]  int_vector;
    logic        vec_chk = 1'b0;
    logic        done = 1'b0;
    int          n_chk = 0, n_bad = 0;

    typedef struct {
        bit        is_vec;
        logic [8:0] exp;
        string     tag;
    } exp_item_t;
    exp_item_t sb[$];

    always #2.5 clk = ~clk;

    pic_cascade_pair u_pic_cascade_pair (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_raise(irq_raise),
        .irq_lower(irq_lower), .irq_num(irq_num), .int_ack(int_ack),
        .int_pending(int_pending), .int_vector(int_vector)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (io_rd || vec_chk) begin
            exp_item_t it;
            logic [8:0] got;
            it  = sb.pop_front();
            got = it.is_vec ? {int_pending, int_vector} : {1'b0, io_rdata};
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %03h expected %03h", it.tag, got, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step();
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        it.is_vec = 1'b0; it.exp = {1'b0, e}; it.tag = tag;
        sb.push_back(it);
        io_addr = a; io_rd = 1'b1;
        step();
        io_rd = 1'b0;
    endtask

    task automatic vec(input logic p, input logic [7:0] v, input string tag);
        exp_item_t it;
        it.is_vec = 1'b1; it.exp = {p, v}; it.tag = tag;
        sb.push_back(it);
        vec_chk = 1'b1;
        step();
        vec_chk = 1'b0;
    endtask

    task automatic line_ev(input logic up, input logic [4:0] n);
        irq_num = n; irq_raise = up; irq_lower = !up;
        step();
        irq_raise = 1'b0; irq_lower = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R2 reset state
        rd(16'h0020, 8'h00, "R2 master request");
        rd(16'h0021, 8'h00, "R2 master mask");
        rd(16'h00A1, 8'h00, "R2 slave mask");
        rd(16'h04D0, 8'h00, "R2 master trigger");
        vec(1'b0, 8'h00, "R2 nothing pending");
        // R1 unmapped
        wr(16'h0060, 8'hFF);
        rd(16'h0060, 8'h00, "R1 unmapped read");
        // R3 master: first word 0x11 -> base, casc, mode, run
        wr(16'h0020, 8'h11);
        wr(16'h0021, 8'h08);
        wr(16'h0021, 8'h04);
        wr(16'h0021, 8'h01);
        rd(16'h0021, 8'h00, "R3 init words leave mask");
        // R3 slave with its own word 0x13: base, mode, run
        wr(16'h00A0, 8'h13);
        wr(16'h00A1, 8'h70);
        wr(16'h00A1, 8'h01);
        wr(16'h00A1, 8'h55);
        rd(16'h00A1, 8'h55, "R4 slave mask after own sequence");
        wr(16'h00A1, 8'h00);
        // R6 trigger masks
        wr(16'h04D0, 8'hFF);
        rd(16'h04D0, 8'hF8, "R6 master trigger mask");
        wr(16'h04D1, 8'hFF);
        rd(16'h04D1, 8'hDE, "R6 slave trigger mask");
        wr(16'h04D0, 8'h00);
        wr(16'h04D1, 8'h00);
        // R7 raise line 5
        line_ev(1'b1, 5'd5);
        rd(16'h0020, 8'h24, "R7 master line plus cascade bit");
        vec(1'b1, 8'h0A, "R10 lowest master bit");
        wr(16'h0021, 8'h04);
        vec(1'b1, 8'h0D, "R10 masked bit skipped");
        // R7 out of range
        line_ev(1'b1, 5'd20);
        rd(16'h0020, 8'h24, "R7 out-of-range master");
        rd(16'h00A0, 8'h00, "R7 out-of-range slave");
        // R7 slave line 11
        line_ev(1'b1, 5'd11);
        rd(16'h00A0, 8'h08, "R7 slave bit 3");
        wr(16'h0021, 8'hFF);
        vec(1'b1, 8'h73, "R10 slave vector");
        // R11 edge ack on slave
        ack();
        wr(16'h00A0, 8'h0B);
        rd(16'h00A0, 8'h08, "R11 slave in-service");
        wr(16'h00A0, 8'h0A);
        rd(16'h00A0, 8'h00, "R11 edge request cleared");
        vec(1'b0, 8'h00, "R9 all masked");
        // R12 specific EOI on slave, level 3
        wr(16'h00A0, 8'h63);
        wr(16'h00A0, 8'h0B);
        rd(16'h00A0, 8'h00, "R12 specific EOI");
        wr(16'h00A0, 8'h0C);
        rd(16'h00A0, 8'h00, "R5 invalid read select");
        // R8 lower line 5
        line_ev(1'b0, 5'd5);
        rd(16'h0020, 8'h04, "R8 lower clears one bit");
        // R11 level line 3
        wr(16'h04D0, 8'h08);
        wr(16'h0021, 8'h00);
        line_ev(1'b1, 5'd3);
        vec(1'b1, 8'h0A, "R10 cascade bit first");
        line_ev(1'b0, 5'd2);
        vec(1'b1, 8'h0B, "R10 line 3");
        ack();
        rd(16'h0020, 8'h08, "R11 level request kept");
        wr(16'h0020, 8'h0B);
        rd(16'h0020, 8'h08, "R5 in-service select");
        wr(16'h0020, 8'h20);
        rd(16'h0020, 8'h00, "R12 nonspecific EOI");
        // R12 lowest cleared among two
        line_ev(1'b1, 5'd0);
        ack();
        rd(16'h0020, 8'h01, "R11 master in-service line 0");
        wr(16'h0020, 8'h0A);
        rd(16'h0020, 8'h0C, "R11 edge line 0 cleared");
        ack();
        wr(16'h0020, 8'h0B);
        rd(16'h0020, 8'h05, "R11 second ack");
        wr(16'h0020, 8'h20);
        rd(16'h0020, 8'h04, "R12 lowest only");
        wr(16'h0020, 8'hE0);
        rd(16'h0020, 8'h04, "R12 other word ignored");
        // R3 restart from run
        wr(16'h0020, 8'h13);
        wr(16'h0021, 8'h30);
        wr(16'h0021, 8'h01);
        rd(16'h0021, 8'h00, "R3 restart keeps mask");
        wr(16'h0020, 8'h0A);
        rd(16'h0020, 8'h08, "R5 request select");
        vec(1'b1, 8'h33, "R3 new base");
        step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule